// File: doc/BRIEF.md
# Burst-Capable Asynchronous Strobe Register Interface

This block is the slave side of an asynchronous, strobe-handshaked processor bus of the 68k kind. A host qualifies each access with an address strobe, a data strobe, a read/write select and a chip select. The block answers with an active-low data-acknowledge. It serves a small bank of internal registers over a shared tri-state data bus.

The rising edge of the address strobe opens an access window. At that edge the block captures the target address. Every completed data-strobe handshake inside the window moves the internal address on by one, so a host can stream through consecutive registers without presenting new addresses. When the address strobe falls, the window closes and the address stops advancing. The next access, single or burst, starts by raising the strobe again.

All bus inputs pass through two-flop synchronizers, and all strobe edges are found on the synchronized copies. The bank contains these registers:

| Offset | Kind | Contents |
|---|---|---|
| 0 | read-only | identity constant |
| 1 | read-only | a status input |
| 2 | read/write | control register, also brought out on a port |
| 3 | read/write | scratch register |
| 4 | cleared by a read | sticky event register |
| 5 | mixed | a writable low byte beside a read-only high byte |

Top module: `sbus_regport`

## Requirements
- R1: After reset, `dtack_n` is 1, the data bus is high-impedance, and `ctrl_out` and `mix_out` are 0.
- R2: On a rising edge of `astb`, the value on `addr` is captured. The first transfer of the window uses that register.
- R3: While `astb` stays high, each acknowledged transfer advances the internal address by one. After `astb` falls, a new rising edge captures a fresh address, and transfers start from that address.
- R4: A transfer with `rw` = 0 is a write. The block captures the bus data when it acknowledges, and commits it to offset 2 (`ctrl_out`) or offset 3 only when `ds_n` returns high.
- R5: With `cs_n` low, `dtack_n` goes low within 12 clocks of `ds_n` falling. It goes high again within 12 clocks of `ds_n` rising.
- R6: The block drives `data` only while `cs_n` = 0, `ds_n` = 0 and `rw` = 1, and it drives the addressed register value there. At all other times `data` is high-impedance.
- R7: A read of offset 0 returns the parameter `DEV_ID` (default 16'hC0DE). A read of offset 1 returns `status_in`. Writes to either offset have no effect.
- R8: Offset 4 collects `evt_set` pulses as sticky bits. A read returns the bits and clears them when `ds_n` rises, so a later read returns 0. An event that arrives during the read is kept rather than cleared. A write to offset 4 has no effect.
- R9: Offset 5 reads as {`status_in[15:8]`, stored byte}. A write stores only `data[7:0]`, and that byte appears on `mix_out`.
- R10: An access to any offset above 5 is still acknowledged. A read of it returns 0, and a write to it changes no register.
- R11: With `cs_n` high, a data-strobe cycle gets no acknowledge, no bus drive and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| astb | input | 1 | Address strobe; high opens an access window |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 9 | Register address |
| data | inout | 16 | Shared data bus |
| dtack_n | output | 1 | Data acknowledge, active low |
| status_in | input | 16 | Read-only status value |
| evt_set | input | 16 | Per-bit event set pulses |
| ctrl_out | output | 16 | Control register contents |
| mix_out | output | 8 | Writable byte of the mixed register |

## Verification
The assertions check these on every cycle:
- The bus drive and the acknowledge only ever follow a chip select, data strobe and read select that were seen two clocks earlier.
- An event pulse is always present in the sticky register one clock later.
- The address moves on by exactly one after each transfer inside a window.
- The control register changes only on a write commit.

The directed scenarios show what depends on the register contents:
- burst streaming across register kinds
- the clear-after-read order on the sticky register, including an event that arrives mid-read
- address re-capture after a window closes
- silence towards unmapped and unselected accesses

// File: rtl/sbus_regport.sv
module sbus_regport #(
  parameter int AW = 9,
  parameter int DW = 16,
  parameter logic [DW-1:0] DEV_ID = 16'hC0DE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          astb,
  input  logic          ds_n,
  input  logic          rw,
  input  logic          cs_n,
  input  logic [AW-1:0] addr,
  inout  wire  [DW-1:0] data,
  output logic          dtack_n,
  input  logic [DW-1:0] status_in,
  input  logic [DW-1:0] evt_set,
  output logic [DW-1:0] ctrl_out,
  output logic [DW/2-1:0] mix_out
);
  localparam int HW = DW / 2;
  localparam logic [AW-1:0] OFF_ID   = AW'(0);
  localparam logic [AW-1:0] OFF_STAT = AW'(1);
  localparam logic [AW-1:0] OFF_CTRL = AW'(2);
  localparam logic [AW-1:0] OFF_SCR  = AW'(3);
  localparam logic [AW-1:0] OFF_EVT  = AW'(4);
  localparam logic [AW-1:0] OFF_MIX  = AW'(5);

  logic [1:0] as_sy, ds_sy, rw_sy, cs_sy;
  logic as_s, ds_s, rw_s, cs_s, as_d, ds_d;
  logic as_rise, ds_start, ds_end;
  logic acc_q, acc_rd, dtk_q;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] rdata_q, wbuf_q, rd_mux, ctrl_q, scr_q, ev_q, ev_clr;
  logic [HW-1:0] mix_q;
  logic xfer_done, wr_commit, rd_done, data_oe;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      as_sy <= '0; ds_sy <= '0; rw_sy <= '0; cs_sy <= '0;
      as_d  <= 1'b0; ds_d <= 1'b0;
    end else begin
      as_sy <= {as_sy[0], astb};
      ds_sy <= {ds_sy[0], ~ds_n};
      rw_sy <= {rw_sy[0], rw};
      cs_sy <= {cs_sy[0], ~cs_n};
      as_d  <= as_s;
      ds_d  <= ds_s;
    end

  assign as_s = as_sy[1];
  assign ds_s = ds_sy[1];
  assign rw_s = rw_sy[1];
  assign cs_s = cs_sy[1];
  assign as_rise  = as_s & ~as_d;
  assign ds_start = ds_s & ~ds_d;
  assign ds_end   = ~ds_s & ds_d;

  assign xfer_done = ds_end & acc_q & dtk_q;
  assign wr_commit = xfer_done & ~acc_rd;
  assign rd_done   = xfer_done & acc_rd;

  always_comb begin
    case (cur_addr)
      OFF_ID:   rd_mux = DEV_ID;
      OFF_STAT: rd_mux = status_in;
      OFF_CTRL: rd_mux = ctrl_q;
      OFF_SCR:  rd_mux = scr_q;
      OFF_EVT:  rd_mux = ev_q;
      OFF_MIX:  rd_mux = {status_in[DW-1:HW], mix_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc_q <= 1'b0; acc_rd <= 1'b0; dtk_q <= 1'b0;
      rdata_q <= '0; wbuf_q <= '0;
    end else if (!cs_s || ds_end) begin
      acc_q <= 1'b0;
      dtk_q <= 1'b0;
    end else if (ds_start) begin
      acc_q   <= 1'b1;
      acc_rd  <= rw_s;
      rdata_q <= rd_mux;
    end else if (acc_q && !dtk_q && ds_s) begin
      dtk_q  <= 1'b1;
      wbuf_q <= data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cur_addr <= '0;
    else if (as_rise) cur_addr <= addr;
    else if (xfer_done && as_s) cur_addr <= cur_addr + AW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q <= '0; scr_q <= '0; mix_q <= '0;
    end else if (wr_commit) begin
      case (cur_addr)
        OFF_CTRL: ctrl_q <= wbuf_q;
        OFF_SCR:  scr_q  <= wbuf_q;
        OFF_MIX:  mix_q  <= wbuf_q[HW-1:0];
        default: ;
      endcase
    end

  assign ev_clr = (rd_done && cur_addr == OFF_EVT) ? rdata_q : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ev_q <= '0;
    else ev_q <= (ev_q & ~ev_clr) | evt_set;

  assign data_oe  = cs_s & ds_s & rw_s & acc_q & acc_rd;
  assign data     = data_oe ? rdata_q : 'z;
  assign dtack_n  = ~(dtk_q & cs_s & ds_s);
  assign ctrl_out = ctrl_q;
  assign mix_out  = mix_q;
endmodule

module sbus_regport_chk #(
  parameter int AW = 9,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          ds_n,
  input logic          rw,
  input logic          dtack_n,
  input logic          data_oe,
  input logic          xfer_done,
  input logic          as_rise,
  input logic          as_s,
  input logic [AW-1:0] cur_addr,
  input logic [DW-1:0] evt_set,
  input logic [DW-1:0] ev_q,
  input logic          wr_commit,
  input logic [DW-1:0] ctrl_q
);
  a_r6_drive_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> ($past(!cs_n, 2) && $past(!ds_n, 2) && $past(rw, 2)));

  a_r5_dtack_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> ($past(!cs_n, 2) && $past(!ds_n, 2)));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && as_s && !as_rise) |=> (cur_addr == $past(cur_addr) + AW'(1)));

  a_r8_event_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((ev_q & $past(evt_set)) == $past(evt_set)));

  a_r4_ctrl_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(ctrl_q));
endmodule

bind sbus_regport sbus_regport_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds_n(ds_n), .rw(rw),
  .dtack_n(dtack_n), .data_oe(data_oe), .xfer_done(xfer_done),
  .as_rise(as_rise), .as_s(as_s), .cur_addr(cur_addr),
  .evt_set(evt_set), .ev_q(ev_q), .wr_commit(wr_commit), .ctrl_q(ctrl_q)
);

// File: tb/tb_sbus_regport.sv
module tb_sbus_regport;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic astb = 1'b0, ds_n = 1'b1, rw = 1'b1, cs_n = 1'b1;
  logic [8:0] addr = '0;
  logic [15:0] status_in = 16'h5A3C, evt_set = '0, host_d = '0;
  logic host_oe = 1'b0;
  wire  [15:0] data;
  logic dtack_n;
  logic [15:0] ctrl_out;
  logic [7:0] mix_out;
  int checks = 0, errors = 0;

  assign data = host_oe ? host_d : 'z;
  always #10 clk = ~clk;

  sbus_regport dut (
    .clk(clk), .rst_n(rst_n), .astb(astb), .ds_n(ds_n), .rw(rw), .cs_n(cs_n),
    .addr(addr), .data(data), .dtack_n(dtack_n), .status_in(status_in),
    .evt_set(evt_set), .ctrl_out(ctrl_out), .mix_out(mix_out));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_win(input logic [8:0] a);
    addr = a; astb = 1'b1; cyc(4);
  endtask

  task automatic close_win();
    astb = 1'b0; cyc(4);
  endtask

  task automatic xfer(input logic rd, input logic [15:0] wd, output logic [15:0] rdv);
    int n;
    rdv = 'x;
    rw = rd; cs_n = 1'b0;
    if (!rd) begin host_d = wd; host_oe = 1'b1; end
    cyc(1);
    ds_n = 1'b0;
    n = 0;
    while (dtack_n && n < 12) begin cyc(1); n++; end
    check("R5 ack arrives", {31'd0, dtack_n}, 32'd0);
    if (rd) rdv = data;
    ds_n = 1'b1;
    n = 0;
    while (!dtack_n && n < 12) begin cyc(1); n++; end
    check("R5 ack released", {31'd0, dtack_n}, 32'd1);
    cyc(2);
    host_oe = 1'b0; cs_n = 1'b1; rw = 1'b1;
    cyc(1);
  endtask

  task automatic single(input logic rd, input logic [8:0] a, input logic [15:0] wd,
                        output logic [15:0] rdv);
    open_win(a); xfer(rd, wd, rdv); close_win();
  endtask

  task automatic pulse_evt(input logic [15:0] v);
    evt_set = v; cyc(1); evt_set = '0;
  endtask

  task automatic t_reset();
    check("R1 dtack idle", {31'd0, dtack_n}, 32'd1);
    check("R1 bus z", {16'd0, data}, {16'd0, 16'hzzzz});
    check("R1 ctrl", {16'd0, ctrl_out}, 32'd0);
    check("R1 mix", {24'd0, mix_out}, 32'd0);
  endtask

  task automatic t_readonly();
    logic [15:0] v;
    single(1'b1, 9'd0, '0, v);
    check("R2 R7 id read", {16'd0, v}, 32'h0000C0DE);
    single(1'b1, 9'd1, '0, v);
    check("R7 status read", {16'd0, v}, {16'd0, status_in});
    single(1'b0, 9'd1, 16'hFFFF, v);
    single(1'b1, 9'd1, '0, v);
    check("R7 status write ignored", {16'd0, v}, {16'd0, status_in});
    single(1'b0, 9'd0, 16'h0000, v);
    single(1'b1, 9'd0, '0, v);
    check("R7 id write ignored", {16'd0, v}, 32'h0000C0DE);
    check("R6 bus z after read", {16'd0, data}, {16'd0, 16'hzzzz});
  endtask

  task automatic t_single_write();
    logic [15:0] v;
    single(1'b0, 9'd2, 16'hA5A5, v);
    check("R4 ctrl_out", {16'd0, ctrl_out}, 32'h0000A5A5);
    single(1'b1, 9'd2, '0, v);
    check("R4 R6 ctrl readback", {16'd0, v}, 32'h0000A5A5);
  endtask

  task automatic t_commit_on_release();
    logic [15:0] v;
    open_win(9'd2);
    rw = 1'b0; cs_n = 1'b0; host_d = 16'h0F0F; host_oe = 1'b1;
    cyc(1); ds_n = 1'b0; cyc(8);
    check("R4 no commit before release", {16'd0, ctrl_out}, 32'h0000A5A5);
    check("R6 no drive on write", {16'd0, data}, 32'h00000F0F);
    ds_n = 1'b1; cyc(5);
    check("R4 commit after release", {16'd0, ctrl_out}, 32'h00000F0F);
    host_oe = 1'b0; cs_n = 1'b1; rw = 1'b1; cyc(1);
    close_win();
    v = '0;
  endtask

  task automatic t_burst();
    logic [15:0] v;
    open_win(9'd2);
    xfer(1'b0, 16'h1111, v);
    xfer(1'b0, 16'h2222, v);
    xfer(1'b0, 16'h7777, v);
    xfer(1'b0, 16'hABCD, v);
    close_win();
    check("R3 burst ctrl", {16'd0, ctrl_out}, 32'h00001111);
    check("R9 mix low byte", {24'd0, mix_out}, 32'h000000CD);
    open_win(9'd2);
    xfer(1'b1, '0, v); check("R3 burst rd 2", {16'd0, v}, 32'h00001111);
    xfer(1'b1, '0, v); check("R3 burst rd 3", {16'd0, v}, 32'h00002222);
    xfer(1'b1, '0, v); check("R8 write to evt ignored", {16'd0, v}, 32'h00000000);
    xfer(1'b1, '0, v); check("R9 mixed read", {16'd0, v}, {16'd0, status_in[15:8], 8'hCD});
    close_win();
    single(1'b1, 9'd3, '0, v);
    check("R3 recapture after close", {16'd0, v}, 32'h00002222);
  endtask

  task automatic t_rur();
    logic [15:0] v;
    pulse_evt(16'h0005);
    pulse_evt(16'h0040);
    single(1'b1, 9'd4, '0, v);
    check("R8 sticky read", {16'd0, v}, 32'h00000045);
    single(1'b1, 9'd4, '0, v);
    check("R8 cleared", {16'd0, v}, 32'h00000000);
    pulse_evt(16'h0002);
    open_win(9'd4);
    rw = 1'b1; cs_n = 1'b0; cyc(1); ds_n = 1'b0;
    while (dtack_n) cyc(1);
    v = data;
    check("R8 read before mid event", {16'd0, v}, 32'h00000002);
    pulse_evt(16'h0100);
    ds_n = 1'b1; cyc(5); cs_n = 1'b1; cyc(1);
    close_win();
    single(1'b1, 9'd4, '0, v);
    check("R8 mid-read event kept", {16'd0, v}, 32'h00000100);
  endtask

  task automatic t_unmapped();
    logic [15:0] v;
    single(1'b0, 9'h1F0, 16'hFFFF, v);
    check("R10 write no effect", {16'd0, ctrl_out}, 32'h00001111);
    single(1'b1, 9'h1F0, '0, v);
    check("R10 read zero", {16'd0, v}, 32'h00000000);
    single(1'b1, 9'd3, '0, v);
    check("R10 scratch unchanged", {16'd0, v}, 32'h00002222);
  endtask

  task automatic t_nocs();
    open_win(9'd2);
    rw = 1'b0; cs_n = 1'b1; host_d = 16'hDEAD; host_oe = 1'b1;
    cyc(1); ds_n = 1'b0; cyc(12);
    check("R11 no ack write", {31'd0, dtack_n}, 32'd1);
    ds_n = 1'b1; cyc(4); host_oe = 1'b0;
    check("R11 no write", {16'd0, ctrl_out}, 32'h00001111);
    rw = 1'b1; cyc(1); ds_n = 1'b0; cyc(12);
    check("R11 no ack read", {31'd0, dtack_n}, 32'd1);
    check("R11 R6 no drive", {16'd0, data}, {16'd0, 16'hzzzz});
    ds_n = 1'b1; cyc(4);
    close_win();
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(3);
    t_readonly();
    t_single_write();
    t_commit_on_release();
    t_burst();
    t_rur();
    t_unmapped();
    t_nocs();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule